// File: doc/BRIEF.md
# Run-Length Expanding Byte Queue

This block is a sixteen-entry queue of nine-bit entries that sits between a host and the data path of a bidirectional parallel port. Each entry holds one data byte and one marker bit. Bytes written on the host port are stored with the marker set. A second write port stores bytes with the marker cleared, so that run-length count entries can be placed in the queue.

On the read side, a small expander decodes the queue as it drains. An entry that has its marker clear and data bit 7 clear is a count `n`. The count itself never reaches the host. Instead, the entry behind it is returned on `n + 1` consecutive reads before the queue moves past it. A read from an empty queue repeats the byte that the previous read returned and leaves the queue state unchanged. Writes that arrive while the queue is full are dropped.

The read result is registered. It appears on `rd_data` after the clock edge that samples `rd_en`. The depth must be a power of two.

Top module: `ecp_rle_fifo`

## Requirements
- R1: After a synchronous reset, `fifo_empty` is 1, `fifo_full` is 0, `rd_data` is 0x00 and no run is in progress, even if a run was under way before the reset.
- R2: A host write (`host_wr_en`) stores the byte with marker bit 1 while fewer than 16 entries are held. `fifo_full` is 1 exactly when 16 entries are held and `fifo_empty` is 1 exactly when none are held.
- R3: A write of either kind while 16 entries are held is discarded, even if a read happens in the same cycle. Later reads never return the discarded byte.
- R4: A raw write (`raw_wr_en`) stores the byte with marker bit 0. If both write enables are high in one cycle, only the host byte is stored.
- R5: A read of an entry that is not a count returns its data byte on `rd_data` after the sampling edge and removes the entry. Entries leave in write order. A marker-0 entry whose bit 7 is 1 is plain data.
- R6: When a read reaches a count entry (marker 0, bit 7 = 0, value `n`) and at least one more entry is held, the count is consumed without being returned. That read and the next `n` reads return the following entry's byte, and only then is that entry removed. A count of 0 gives exactly one return.
- R7: When a read reaches a count entry that is the only entry held, the count is consumed and the read returns the previous byte. The next entry written is then returned `n + 1` times.
- R8: A read while the queue is empty returns the previous `rd_data` again, and `fifo_empty` stays 1.
- R9: A write and a single-entry read in the same cycle leave the number of held entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Push `host_wr_data` with marker 1 |
| host_wr_data | input | 8 | Host data byte |
| raw_wr_en | input | 1 | Push `raw_wr_data` with marker 0 |
| raw_wr_data | input | 8 | Byte stored with marker clear (count or data) |
| rd_en | input | 1 | Host read request |
| rd_data | output | 8 | Registered read result |
| fifo_full | output | 1 | Sixteen entries held |
| fifo_empty | output | 1 | No entries held |

## Verification
Two functions can fall in the same cycle: a write landing and a read draining. The bench provokes this in two ways. First it fills the queue to fifteen entries and raises a host write and a read on the same edge; one further write must then raise `fifo_full`, which proves the occupancy did not change. Second, a write issued after an underrun-consumed count must become the repeated byte. Write-order drain values and repeat counts are judged against values the bench predicts from the requirements.

// File: rtl/ecp_rle_pkg.sv
package ecp_rle_pkg;

    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 16;

    typedef struct packed {
        logic              mark;
        logic [DATA_W-1:0] data;
    } entry_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_PLAIN,
        ACT_REPEAT,
        ACT_COUNT
    } rd_act_t;

    function automatic logic is_run_count(entry_t e);
        return (!e.mark) && (!e.data[DATA_W-1]);
    endfunction

endpackage

// File: rtl/ecp_fifo_store.sv
module ecp_fifo_store
    import ecp_rle_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  entry_t                   push_entry,
    input  logic [1:0]               pop_n,
    output entry_t                   head,
    output entry_t                   second,
    output logic [$clog2(DEPTH):0]   occ,
    output logic                     full,
    output logic                     empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int OW = AW + 1;

    entry_t         mem [DEPTH];
    logic [AW-1:0]  wp;
    logic [AW-1:0]  rp;
    logic [OW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                wp <= wp + AW'(1);
            end
            rp  <= rp + AW'(pop_n);
            cnt <= cnt + OW'(push) - OW'(pop_n);
        end
    end

    assign head   = mem[rp];
    assign second = mem[rp + AW'(1)];
    assign occ    = cnt;
    assign full   = (cnt == OW'(DEPTH));
    assign empty  = (cnt == '0);

    // R3: a full queue with no read stays full
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (full && pop_n == 2'd0) |=> full);

    // R8: an empty queue with no write stays empty
    p_empty_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (empty && !push) |=> empty);

    // R9: write plus single removal keeps occupancy
    p_occ_steady_r9: assert property (@(posedge clk) disable iff (rst)
        (push && pop_n == 2'd1) |=> (occ == $past(occ)));

    // R2: occupancy never passes the depth
    p_occ_bound_r2: assert property (@(posedge clk) disable iff (rst)
        occ <= OW'(DEPTH));

endmodule

// File: rtl/ecp_rle_reader.sv
module ecp_rle_reader
    import ecp_rle_pkg::*;
#(
    parameter int OW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  entry_t            head,
    input  entry_t            second,
    input  logic [OW-1:0]     occ,
    output logic [1:0]        pop_n,
    output logic [DATA_W-1:0] rd_data
);
    logic              run_on;
    logic [DATA_W-1:0] run_rem;
    rd_act_t           act;

    logic              nxt_on;
    logic [DATA_W-1:0] nxt_rem;
    logic [DATA_W-1:0] nxt_data;

    always_comb begin
        act = ACT_HOLD;
        if (rd_en && occ != '0) begin
            if (run_on) begin
                act = ACT_REPEAT;
            end else if (is_run_count(head)) begin
                act = ACT_COUNT;
            end else begin
                act = ACT_PLAIN;
            end
        end
    end

    always_comb begin
        pop_n    = 2'd0;
        nxt_on   = run_on;
        nxt_rem  = run_rem;
        nxt_data = rd_data;
        unique case (act)
            ACT_HOLD: begin
            end
            ACT_PLAIN: begin
                nxt_data = head.data;
                pop_n    = 2'd1;
            end
            ACT_REPEAT: begin
                nxt_data = head.data;
                if (run_rem == '0) begin
                    pop_n  = 2'd1;
                    nxt_on = 1'b0;
                end else begin
                    nxt_rem = run_rem - DATA_W'(1);
                end
            end
            ACT_COUNT: begin
                if (occ >= OW'(2)) begin
                    nxt_data = second.data;
                    if (head.data == '0) begin
                        pop_n = 2'd2;
                    end else begin
                        pop_n   = 2'd1;
                        nxt_on  = 1'b1;
                        nxt_rem = head.data - DATA_W'(1);
                    end
                end else begin
                    pop_n   = 2'd1;
                    nxt_on  = 1'b1;
                    nxt_rem = head.data;
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_on  <= 1'b0;
            run_rem <= '0;
            rd_data <= '0;
        end else begin
            run_on  <= nxt_on;
            run_rem <= nxt_rem;
            rd_data <= nxt_data;
        end
    end

    // R8: never remove more entries than are held
    p_pop_bound_r8: assert property (@(posedge clk) disable iff (rst)
        OW'(pop_n) <= occ);

    // R8: a read from an empty queue repeats the previous byte
    p_underrun_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && occ == '0) |=> $stable(rd_data));

    // R6: while repeats remain, the repeated entry is not removed
    p_run_keeps_head_r6: assert property (@(posedge clk) disable iff (rst)
        (run_on && run_rem != '0 && rd_en) |-> (pop_n == 2'd0));

    // R6: a count byte is never handed out while a run is armed
    p_count_hidden_r6: assert property (@(posedge clk) disable iff (rst)
        (!run_on && rd_en && occ >= OW'(2) && is_run_count(head))
        |=> (rd_data == $past(second.data)));

endmodule

// File: rtl/ecp_rle_fifo.sv
module ecp_rle_fifo
    import ecp_rle_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic              raw_wr_en,
    input  logic [DATA_W-1:0] raw_wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              fifo_full,
    output logic              fifo_empty
);
    localparam int OW = $clog2(DEPTH) + 1;

    entry_t        wr_entry;
    entry_t        head;
    entry_t        second;
    logic          push;
    logic [1:0]    pop_n;
    logic [OW-1:0] occ;

    always_comb begin
        if (host_wr_en) begin
            wr_entry = '{mark: 1'b1, data: host_wr_data};
        end else begin
            wr_entry = '{mark: 1'b0, data: raw_wr_data};
        end
    end

    assign push = (host_wr_en || raw_wr_en) && !fifo_full;

    ecp_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_entry (wr_entry),
        .pop_n      (pop_n),
        .head       (head),
        .second     (second),
        .occ        (occ),
        .full       (fifo_full),
        .empty      (fifo_empty)
    );

    ecp_rle_reader #(.OW(OW)) u_reader (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .head    (head),
        .second  (second),
        .occ     (occ),
        .pop_n   (pop_n),
        .rd_data (rd_data)
    );

    // R1: reset leaves the queue empty and not full
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (fifo_empty && !fifo_full && rd_data == '0));

    // R4: a host write into an empty queue is marked
    p_host_mark_r4: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty && host_wr_en) |=> head.mark);

endmodule

// File: tb/ecp_rle_fifo_tb.sv
`timescale 1ns/1ps
module ecp_rle_fifo_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr_en;
    logic [7:0] host_wr_data;
    logic       raw_wr_en;
    logic [7:0] raw_wr_data;
    logic       rd_en;
    logic [7:0] rd_data;
    logic       fifo_full;
    logic       fifo_empty;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ecp_rle_fifo u_dut (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .raw_wr_en(raw_wr_en), .raw_wr_data(raw_wr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push_host(input logic [7:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic push_raw(input logic [7:0] d);
        @(negedge clk);
        raw_wr_en = 1'b1; raw_wr_data = d;
        @(negedge clk);
        raw_wr_en = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [7:0] exp);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, int'(rd_data), int'(exp));
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 empty", int'(fifo_empty), 1);
        check("R1 full", int'(fifo_full), 0);
        check("R1 rd_data", int'(rd_data), 0);
    endtask

    task automatic t_order_and_underrun();
        push_host(8'hA1); push_host(8'hA2); push_host(8'hA3);
        check("R2 not empty", int'(fifo_empty), 0);
        read_chk("R5 first", 8'hA1);
        read_chk("R5 second", 8'hA2);
        read_chk("R5 third", 8'hA3);
        check("R2 empty after drain", int'(fifo_empty), 1);
        read_chk("R8 underrun repeats", 8'hA3);
        check("R8 still empty", int'(fifo_empty), 1);
    endtask

    task automatic t_full();
        for (int i = 0; i < 16; i++) push_host(8'h80 + 8'(i));
        check("R2 full at 16", int'(fifo_full), 1);
        push_host(8'h55);
        push_raw(8'h05);
        check("R3 still full", int'(fifo_full), 1);
        for (int i = 0; i < 16; i++) read_chk("R3 drain", 8'h80 + 8'(i));
        check("R3 empty after 16", int'(fifo_empty), 1);
        read_chk("R3 dropped byte absent", 8'h8F);
    endtask

    task automatic t_raw_port();
        push_raw(8'h85);
        read_chk("R5 marker0 bit7 plain", 8'h85);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_data = 8'h11;
        raw_wr_en  = 1'b1; raw_wr_data  = 8'h03;
        @(negedge clk);
        host_wr_en = 1'b0; raw_wr_en = 1'b0;
        read_chk("R4 host wins", 8'h11);
        check("R4 single entry", int'(fifo_empty), 1);
    endtask

    task automatic t_runs();
        push_raw(8'h02); push_host(8'hAB); push_host(8'hCD);
        read_chk("R6 rep1", 8'hAB);
        read_chk("R6 rep2", 8'hAB);
        read_chk("R6 rep3", 8'hAB);
        read_chk("R6 after run", 8'hCD);
        check("R6 empty", int'(fifo_empty), 1);
        push_raw(8'h00); push_host(8'h77); push_host(8'h66);
        read_chk("R6 count0 once", 8'h77);
        read_chk("R6 count0 next", 8'h66);
        check("R6 count0 empty", int'(fifo_empty), 1);
    endtask

    task automatic t_lone_count();
        push_raw(8'h01);
        read_chk("R7 lone count returns last", 8'h66);
        check("R7 count consumed", int'(fifo_empty), 1);
        push_host(8'h99);
        read_chk("R7 rep1", 8'h99);
        read_chk("R7 rep2", 8'h99);
        check("R7 removed after run", int'(fifo_empty), 1);
    endtask

    task automatic t_concurrent();
        for (int i = 0; i < 15; i++) push_host(8'h20 + 8'(i));
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_data = 8'h60; rd_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0; rd_en = 1'b0;
        check("R9 read value", int'(rd_data), 8'h20);
        check("R9 not full at 15", int'(fifo_full), 0);
        push_host(8'h61);
        check("R9 full at 16", int'(fifo_full), 1);
        for (int i = 1; i < 15; i++) read_chk("R9 drain", 8'h20 + 8'(i));
        read_chk("R9 drain pushed", 8'h60);
        read_chk("R9 drain last", 8'h61);
    endtask

    task automatic t_reset_mid_run();
        push_raw(8'h03); push_host(8'h42); push_host(8'h43);
        read_chk("R6 run start", 8'h42);
        do_reset();
        check("R1 mid-run empty", int'(fifo_empty), 1);
        check("R1 mid-run rd_data", int'(rd_data), 0);
        push_host(8'h10);
        read_chk("R1 run cleared", 8'h10);
        check("R1 run cleared empty", int'(fifo_empty), 1);
    endtask

    initial begin
        rst = 1'b1; host_wr_en = 0; host_wr_data = 0;
        raw_wr_en = 0; raw_wr_data = 0; rd_en = 0;
        t_reset();
        t_order_and_underrun();
        t_full();
        t_raw_port();
        t_runs();
        t_lone_count();
        t_concurrent();
        t_reset_mid_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule